// File: doc/BRIEF.md
# Shared Bus Priority Arbiter with Ownership Lock

This block decides which of four bus masters may drive a shared on-chip bus. A master raises its request line and waits for its grant line before it puts an address, command or data on the bus. The grant is registered. It moves to a new owner only on a clock edge. That edge is either one where the bus reports a finished transfer, or one where nobody owns the bus.

Masters are ranked by fixed priority, with master 0 highest. Each master that waits has an age counter. When that counter reaches a threshold set at an input port, the master is promoted above every fixed rank, so a low-ranked master cannot starve.

The current owner can hold its lock line to keep the bus through a run of transfers, for example a read-modify-write on a semaphore word. A higher-ranked request cannot break into such a run. Only the owner's lock line is looked at. When no master requests, the grant parks on nobody and an idle flag is raised.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it, all grant bits are 0 and `bus_idle` is 1. Reset clears every age counter to 0, so no master is promoted early after reset.
- R2: At most one bit of `grant` is 1 in any cycle. Bit i of `grant` belongs to master i.
- R3: When the bus has no owner and some `req` bits are 1 (none promoted), the grant goes on the next edge to the lowest-index requester. Index 0 is the highest priority.
- R4: If no owner remains after an edge and no `req` bit is 1, `grant` is all zeros and `bus_idle` is 1.
- R5: While an owner exists and `xfer_done` is 0, the grant does not change, whatever the other requests are.
- R6: On an edge where `xfer_done` is 1 and the owner's `lock` bit is 0, the arbiter picks a new owner from the current requests. The result shows from that edge on. The old owner may win again if it still requests.
- R7: On an edge where `xfer_done` is 1 and the owner's `lock` bit is 1, the owner keeps the grant, even if a higher-priority master requests.
- R8: A `lock` bit of a master that is not the owner has no effect on arbitration.
- R9: A master's age counter rises by 1 on each edge where it requests and is not the next owner. It saturates at 2^AGE_W-1 (15 by default). It returns to 0 on an edge where the master becomes or stays owner, or where its request is 0.
- R10: When the arbiter picks a new owner, a requester whose age is greater than or equal to `age_limit` is promoted. Promoted requesters win over all others, and among promoted requesters the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Bus request, one bit per master |
| lock | input | 4 | Ownership hold, one bit per master; only the owner's bit counts |
| xfer_done | input | 1 | Strobe from the bus: the owner's current transfer finishes this cycle |
| age_limit | input | 4 | Wait threshold for promotion |
| grant | output | 4 | One-hot (or zero) bus grant, one bit per master |
| bus_idle | output | 1 | 1 when no master owns the bus |

## Verification
Every result of this block shows on the first rising edge after the inputs are sampled. That covers the new owner after a release, the kept owner under a lock, and the idle flag. The age counters are not visible at the ports, so their effect is judged by which master wins that same edge. The bench drives each input set on a falling edge and pushes the expected `grant`/`bus_idle` pair into a queue. A monitor pops one entry 1 ns after each following rising edge, so every comparison lands exactly one register stage after its stimulus. Reset state is checked on a falling edge while reset is held.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Index of the lowest set bit; 0 when none is set (callers gate with a valid).
  function automatic int lowest_set(input logic [31:0] vec);
    for (int i = 0; i < 32; i++) begin
      if (vec[i]) return i;
    end
    return 0;
  endfunction

  // Saturating increment toward a ceiling.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? v : v + 32'd1;
  endfunction

  // One-hot decode of an index into a vector of up to 32 bits.
  function automatic logic [31:0] onehot_of(input int idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/arb_age_bank.sv
module arb_age_bank #(
  parameter int N_MASTERS = 4,
  parameter int AGE_W     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_MASTERS-1:0]               req,
  input  logic [N_MASTERS-1:0]               grant_nxt,
  output logic [N_MASTERS-1:0][AGE_W-1:0]    age
);
  import arb_pkg::*;

  localparam logic [31:0] AGE_TOP = 32'((64'd1 << AGE_W) - 64'd1);

  generate
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_age
      logic             waiting;
      logic [AGE_W-1:0] cnt_q;

      // A master ages only while it asks and is not the owner after this edge.
      assign waiting = req[g] & ~grant_nxt[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (waiting) begin
          cnt_q <= AGE_W'(sat_inc(32'(cnt_q), AGE_TOP));
        end else begin
          cnt_q <= '0;
        end
      end

      assign age[g] = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int N_MASTERS = 4,
  parameter int AGE_W     = 4,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0]               req,
  input  logic [N_MASTERS-1:0][AGE_W-1:0]    age,
  input  logic [AGE_W-1:0]                   age_limit,
  output logic                               win_v,
  output logic [IDX_W-1:0]                   win_idx,
  output logic [N_MASTERS-1:0]               promoted
);
  import arb_pkg::*;

  generate
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_promo
      assign promoted[g] = req[g] & (age[g] >= age_limit);
    end
  endgenerate

  // Promoted requesters form their own, higher tier; fixed order inside each tier.
  always_comb begin
    win_v = |req;
    if (|promoted) begin
      win_idx = IDX_W'(lowest_set(32'(promoted)));
    end else begin
      win_idx = IDX_W'(lowest_set(32'(req)));
    end
  end

endmodule

// File: rtl/arb_owner.sv
module arb_owner #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_v,
  input  logic [IDX_W-1:0]      win_idx,
  input  logic                  xfer_done,
  input  logic [N_MASTERS-1:0]  lock,
  output logic                  owner_v,
  output logic [IDX_W-1:0]      owner_idx,
  output logic [N_MASTERS-1:0]  grant,
  output logic [N_MASTERS-1:0]  grant_nxt,
  output logic                  rearb
);
  import arb_pkg::*;

  logic             owned_lock;
  logic             nxt_v;
  logic [IDX_W-1:0] nxt_idx;

  // Only the owner's lock bit is consulted.
  assign owned_lock = owner_v & lock[owner_idx];
  assign rearb      = ~owner_v | (xfer_done & ~owned_lock);

  always_comb begin
    nxt_v   = owner_v;
    nxt_idx = owner_idx;
    if (rearb) begin
      nxt_v   = win_v;
      nxt_idx = win_v ? win_idx : '0;
    end
    grant_nxt = nxt_v ? N_MASTERS'(onehot_of(int'(nxt_idx))) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_v   <= 1'b0;
      owner_idx <= '0;
      grant     <= '0;
    end else begin
      owner_v   <= nxt_v;
      owner_idx <= nxt_idx;
      grant     <= grant_nxt;
    end
  end

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int AGE_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_MASTERS-1:0]  req,
  input  logic [N_MASTERS-1:0]  lock,
  input  logic                  xfer_done,
  input  logic [AGE_W-1:0]      age_limit,
  output logic [N_MASTERS-1:0]  grant,
  output logic                  bus_idle
);
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0][AGE_W-1:0] age_w;
  logic [N_MASTERS-1:0]            promoted_w;
  logic [N_MASTERS-1:0]            grant_nxt_w;
  logic                            win_v_w;
  logic [IDX_W-1:0]                win_idx_w;
  logic                            owner_v_w;
  logic [IDX_W-1:0]                owner_idx_w;
  logic                            rearb_w;

  arb_age_bank #(.N_MASTERS(N_MASTERS), .AGE_W(AGE_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .grant_nxt (grant_nxt_w),
    .age       (age_w)
  );

  arb_select #(.N_MASTERS(N_MASTERS), .AGE_W(AGE_W)) u_sel (
    .req       (req),
    .age       (age_w),
    .age_limit (age_limit),
    .win_v     (win_v_w),
    .win_idx   (win_idx_w),
    .promoted  (promoted_w)
  );

  arb_owner #(.N_MASTERS(N_MASTERS)) u_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_v     (win_v_w),
    .win_idx   (win_idx_w),
    .xfer_done (xfer_done),
    .lock      (lock),
    .owner_v   (owner_v_w),
    .owner_idx (owner_idx_w),
    .grant     (grant),
    .grant_nxt (grant_nxt_w),
    .rearb     (rearb_w)
  );

  assign bus_idle = ~owner_v_w;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_MASTERS-1:0]  req,
  input logic [N_MASTERS-1:0]  lock,
  input logic                  xfer_done,
  input logic [N_MASTERS-1:0]  grant,
  input logic                  bus_idle,
  input logic                  rearb,
  input logic                  win_v,
  input logic [IDX_W-1:0]      win_idx,
  input logic [N_MASTERS-1:0]  promoted
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (grant == '0 && bus_idle));

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_pick_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && win_v) |=> (grant == N_MASTERS'(1) << $past(win_idx)));

  assert_idle_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle == (grant == '0));

  assert_park_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && req == '0) |=> bus_idle);

  assert_hold_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && !bus_idle) |=> $stable(grant));

  assert_lock_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && (grant & lock) != '0) |=> $stable(grant));

  assert_foreign_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !bus_idle && (grant & lock) == '0) |-> rearb);

  assert_promoted_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && promoted != '0) |-> promoted[win_idx]);

endmodule

bind shared_bus_arbiter arb_checker #(.N_MASTERS(N_MASTERS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .lock      (lock),
  .xfer_done (xfer_done),
  .grant     (grant),
  .bus_idle  (bus_idle),
  .rearb     (rearb_w),
  .win_v     (win_v_w),
  .win_idx   (win_idx_w),
  .promoted  (promoted_w)
);

// File: tb/shared_bus_arbiter_tb.sv
module shared_bus_arbiter_tb_top;
  localparam int NM      = 4;
  localparam int AGE_MAX = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] req;
  logic [NM-1:0] lock;
  logic          xfer_done;
  logic [3:0]    age_limit;
  logic [NM-1:0] grant;
  logic          bus_idle;

  always #5 clk = ~clk;

  shared_bus_arbiter #(.N_MASTERS(NM), .AGE_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .xfer_done(xfer_done),
    .age_limit(age_limit), .grant(grant), .bus_idle(bus_idle)
  );

  typedef struct {
    logic [NM-1:0] g;
    logic          idle;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   run_over = 0;

  // Reference model state, written from the requirements.
  int m_age[NM];
  bit m_own_v;
  int m_own;

  task automatic model_reset();
    for (int i = 0; i < NM; i++) m_age[i] = 0;
    m_own_v = 0;
    m_own   = 0;
  endtask

  task automatic model_edge(input logic [NM-1:0] r, input logic [NM-1:0] l, input logic d);
    bit rel;
    bit found;
    int pick;
    rel = !m_own_v || (d && l[m_own] == 1'b0);
    if (rel) begin
      found = 0;
      pick  = 0;
      for (int i = 0; i < NM; i++)
        if (!found && r[i] && m_age[i] >= int'(age_limit)) begin found = 1; pick = i; end
      for (int i = 0; i < NM; i++)
        if (!found && r[i]) begin found = 1; pick = i; end
      m_own_v = found;
      m_own   = pick;
    end
    for (int i = 0; i < NM; i++) begin
      if (r[i] && !(m_own_v && m_own == i))
        m_age[i] = (m_age[i] < AGE_MAX) ? m_age[i] + 1 : AGE_MAX;
      else
        m_age[i] = 0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NM-1:0] act, input logic [NM-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: one input set per cycle, expected result queued for the next edge.
  task automatic drive(input logic [NM-1:0] r, input logic [NM-1:0] l, input logic d,
                       input string tag, input int times = 1);
    exp_t e;
    repeat (times) begin
      @(negedge clk);
      req = r; lock = l; xfer_done = d;
      model_edge(r, l, d);
      e.g    = m_own_v ? NM'(1 << m_own) : '0;
      e.idle = !m_own_v;
      e.tag  = tag;
      sbq.push_back(e);
    end
  endtask

  // Monitor: compares one queued item just after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(grant == e.g, e.tag, "grant", grant, e.g);
        check(bus_idle == e.idle, e.tag, "bus_idle", NM'(bus_idle), NM'(e.idle));
        check($onehot0(grant), "R2", "onehot0", grant, e.g);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; lock = '0; xfer_done = 1'b0;
    model_reset();
    @(negedge clk);
    check(grant == '0, "R1", "grant in reset", grant, '0);
    check(bus_idle == 1'b1, "R1", "idle in reset", NM'(bus_idle), NM'(1));
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_over) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; lock = '0; xfer_done = 1'b0; age_limit = 4'd15;
    model_reset();
    do_reset();

    // R4: nothing requested, bus parks on nobody
    drive(4'b0000, 4'b0000, 1'b0, "R4", 2);
    // R3: idle bus, master1 beats master3
    drive(4'b1010, 4'b0000, 1'b0, "R3");
    // R5: master0 arrives, owner 1 keeps the bus without done
    drive(4'b1011, 4'b0000, 1'b0, "R5", 3);
    // R6: done without lock, master0 takes over
    drive(4'b1011, 4'b0000, 1'b1, "R6");
    // R6: master0 drops, done -> master1 next
    drive(4'b1010, 4'b0000, 1'b1, "R6");
    drive(4'b1000, 4'b0000, 1'b1, "R6");
    // R7: owner 3 locks; master0 requests but cannot break in
    drive(4'b1001, 4'b1000, 1'b1, "R7", 3);
    // R6: lock dropped, master0 wins on done
    drive(4'b1001, 4'b0000, 1'b1, "R6");
    // R8: master2 locks while master0 owns; done releases anyway
    drive(4'b0110, 4'b0100, 1'b1, "R8");
    drive(4'b0100, 4'b0100, 1'b0, "R8");
    // R4: everyone leaves on done
    drive(4'b0000, 4'b0000, 1'b1, "R4", 2);

    // R10: promotion with threshold 3, master0 and master3 contend
    age_limit = 4'd3;
    drive(4'b1001, 4'b0000, 1'b1, "R10", 7);
    drive(4'b0000, 4'b0000, 1'b1, "R4");

    // R9: age clears when the request drops
    drive(4'b1001, 4'b0000, 1'b1, "R9", 2);
    drive(4'b0001, 4'b0000, 1'b1, "R9");
    drive(4'b1001, 4'b0000, 1'b1, "R9", 4);
    drive(4'b0000, 4'b0000, 1'b1, "R9");

    // R9: saturation at 15, no wrap after a long wait
    age_limit = 4'd15;
    drive(4'b0001, 4'b0000, 1'b0, "R9");
    drive(4'b1001, 4'b0000, 1'b0, "R9", 20);
    drive(4'b1001, 4'b0000, 1'b1, "R9");
    drive(4'b0000, 4'b0000, 1'b1, "R9");

    // R10: two promoted masters, lowest index among them wins
    age_limit = 4'd2;
    drive(4'b0001, 4'b0000, 1'b0, "R10");
    drive(4'b1101, 4'b0000, 1'b0, "R10", 3);
    drive(4'b1101, 4'b0000, 1'b1, "R10", 3);
    drive(4'b0000, 4'b0000, 1'b1, "R10");

    // R1: reset mid-wait clears ages
    age_limit = 4'd4;
    drive(4'b0001, 4'b0000, 1'b0, "R1");
    drive(4'b1001, 4'b0000, 1'b0, "R1", 6);
    @(posedge clk); #2;
    do_reset();
    drive(4'b1001, 4'b0000, 1'b1, "R1", 4);

    repeat (3) @(posedge clk);
    #2;
    run_over = 1;
    finish_run();
  end

endmodule